// File: doc/BRIEF.md
# Channel-Status and User-Bit Capture

This block sits behind an S/PDIF biphase decoder and gathers the two per-frame side bits: the channel-status bit and the user bit. It counts 192 left subframes from a block-start marker, packs the collected bits into sixteen-bit words, and publishes each finished block as two read-only arrays of twelve words, one for status and one for user data. Software or a register front end reads either array through a simple address/data port.

When a block completes, the block pulses a block-end event. In the same cycle it raises a status-changed event and/or a user-changed event when the new block's bits differ from those of the block published before it. Words are filled into a hidden bank while the visible bank stays frozen, and the two banks swap roles only when a block completes. A reader therefore sees either the old block or the new one, never a mixture. A block cut short by an early marker is dropped without a trace.

Top module: `chstat_ubit_capture`

## Requirements
- R1: After reset, blk_end, cs_chg and ud_chg are 0, and every read of either array returns 0 until the first block has completed.
- R2: Only a strobe with frm_left=1 is a frame. A strobe with frm_left=0, including its bits and its marker, has no effect.
- R3: Status bit k of a block, where bit 0 is the frame strobed together with blk_mark, is stored in status word k/16 at bit position k mod 16. Byte 2i of the block is therefore bits 7:0 of word i, and byte 2i+1 is bits 15:8.
- R4: User bits are stored in the user array with the same word and bit layout as R3.
- R5: blk_end pulses high for one cycle, starting in the cycle after the 192nd frame of a block is sampled. It stays low for every earlier frame.
- R6: Frames are ignored before the first marker after reset, and also after a completed block until the next marker arrives.
- R7: cs_chg is high together with blk_end exactly when the status bits of the new block differ from the previously published block. For the first block after reset, cs_chg is always high.
- R8: ud_chg follows the same rule as R7, applied to the user bits.
- R9: While a block is being collected, both arrays keep returning the previously published block.
- R10: A marker that arrives before 192 frames have been collected discards the partial block, raises no event, and starts a new block at that frame. Change detection then compares against the last published block.
- R11: Read data appears one cycle after the address is presented. A word address of 12 or above returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_stb | input | 1 | One-cycle strobe per received subframe |
| frm_left | input | 1 | Strobed subframe is the left one |
| blk_mark | input | 1 | Strobed frame is bit 0 of a new block |
| c_bit | input | 1 | Channel-status bit of the strobed subframe |
| u_bit | input | 1 | User bit of the strobed subframe |
| cs_raddr | input | 4 | Status array word address |
| cs_rdata | output | 16 | Status word, one cycle after the address |
| ud_raddr | input | 4 | User array word address |
| ud_rdata | output | 16 | User word, one cycle after the address |
| blk_end | output | 1 | Pulse: a full block has been published |
| cs_chg | output | 1 | Pulse with blk_end: status bits changed |
| ud_chg | output | 1 | Pulse with blk_end: user bits changed |

## Verification
Random 192-bit status and user patterns are compared word by word against the bit-to-word mapping, and a directed byte pattern pins down the low-byte-first order. Change detection is exercised in four ways: a repeated block with no change, a single flipped status bit at the last position, a single flipped user bit at position 0, and random mixes. Together these separate the two change flags from each other and catch a comparison that misses the first or last word. Interleaved right subframes carry random bits and markers, which shows that they are ignored. Markerless frames and an aborted partial block followed by a block equal to the previous one show that nothing is published or compared early.

// File: rtl/csu_pkg.sv
package csu_pkg;
  localparam int N_STREAMS = 2;
  localparam int STRM_STATUS = 0;
  localparam int STRM_USER = 1;

  // control bundle from the frame sequencer to each word bank
  typedef struct packed {
    logic take;       // a left frame is being captured this cycle
    logic first;      // it is bit 0 of a block
    logic last;       // it completes a block
    logic vbank;      // bank currently visible to readers
    logic have_prev;  // a block has been published since reset
  } seq_ctl_t;
endpackage

// File: rtl/csu_frame_seq.sv
module csu_frame_seq
  import csu_pkg::*;
#(
  parameter int BLK_FRAMES = 192,
  localparam int CW = $clog2(BLK_FRAMES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frm_stb,
  input  logic          frm_left,
  input  logic          blk_mark,
  output seq_ctl_t      ctl,
  output logic [CW-1:0] pos,
  output logic          blk_end
);
  localparam logic [CW-1:0] LAST_POS = CW'(BLK_FRAMES - 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic          vbank_q;
  logic          have_prev_q;
  logic          take;
  logic          is_last;

  always_comb begin
    take    = frm_stb && frm_left && (blk_mark || active);
    pos     = blk_mark ? '0 : cnt;
    is_last = take && (pos == LAST_POS);
    ctl.take      = take;
    ctl.first     = take && blk_mark;
    ctl.last      = is_last;
    ctl.vbank     = vbank_q;
    ctl.have_prev = have_prev_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active      <= 1'b0;
      cnt         <= '0;
      vbank_q     <= 1'b0;
      have_prev_q <= 1'b0;
      blk_end     <= 1'b0;
    end else begin
      blk_end <= is_last;
      if (take) begin
        if (is_last) begin
          active      <= 1'b0;
          cnt         <= '0;
          vbank_q     <= ~vbank_q;
          have_prev_q <= 1'b1;
        end else begin
          active <= 1'b1;
          cnt    <= pos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/csu_word_bank.sv
module csu_word_bank
  import csu_pkg::*;
#(
  parameter int BLK_FRAMES = 192,
  parameter int WORD_W = 16,
  localparam int CW = $clog2(BLK_FRAMES),
  localparam int N_WORDS = BLK_FRAMES / WORD_W,
  localparam int AW = $clog2(N_WORDS),
  localparam int SW = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_ctl_t          ctl,
  input  logic [CW-1:0]     pos,
  input  logic              bit_in,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata,
  output logic              chg
);
  localparam int DEPTH = 2 ** (AW + 1);
  localparam logic [AW:0] NW = (AW + 1)'(N_WORDS);
  localparam logic [SW-1:0] TOP_BIT = SW'(WORD_W - 1);

  // two banks: {bank, word index}; one visible, one being filled
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] new_word;
  logic [WORD_W-1:0] prev_word;
  logic [SW-1:0]     bit_sel;
  logic [AW-1:0]     word_idx;
  logic              word_full;
  logic              diff_acc;
  logic              diff_next;

  always_comb begin
    bit_sel   = SW'(pos % WORD_W);
    word_idx  = AW'(pos / WORD_W);
    new_word  = acc;
    new_word[bit_sel] = bit_in;
    word_full = ctl.take && (bit_sel == TOP_BIT);
    prev_word = mem[{ctl.vbank, word_idx}];
    diff_next = (ctl.first ? 1'b0 : diff_acc) ||
                (word_full && (prev_word != new_word));
  end

  // word write into the hidden bank (no reset, RAM-style)
  always_ff @(posedge clk) begin
    if (word_full) mem[{~ctl.vbank, word_idx}] <= new_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      diff_acc <= 1'b0;
      chg      <= 1'b0;
    end else begin
      chg <= 1'b0;
      if (ctl.take) begin
        acc      <= new_word;
        diff_acc <= diff_next;
        if (ctl.last) chg <= diff_next || !ctl.have_prev;
      end
    end
  end

  // registered read of the visible bank
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (ctl.have_prev && ({1'b0, raddr} < NW)) begin
      rdata <= mem[{ctl.vbank, raddr}];
    end else begin
      rdata <= '0;
    end
  end
endmodule

// File: rtl/chstat_ubit_capture.sv
module chstat_ubit_capture
  import csu_pkg::*;
#(
  parameter int BLK_FRAMES = 192,
  parameter int WORD_W = 16,
  localparam int CW = $clog2(BLK_FRAMES),
  localparam int N_WORDS = BLK_FRAMES / WORD_W,
  localparam int AW = $clog2(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_stb,
  input  logic              frm_left,
  input  logic              blk_mark,
  input  logic              c_bit,
  input  logic              u_bit,
  input  logic [AW-1:0]     cs_raddr,
  output logic [WORD_W-1:0] cs_rdata,
  input  logic [AW-1:0]     ud_raddr,
  output logic [WORD_W-1:0] ud_rdata,
  output logic              blk_end,
  output logic              cs_chg,
  output logic              ud_chg
);
  seq_ctl_t          ctl;
  logic [CW-1:0]     pos;
  logic [WORD_W-1:0] rd_w  [N_STREAMS];
  logic              chg_w [N_STREAMS];

  csu_frame_seq #(.BLK_FRAMES(BLK_FRAMES)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .frm_stb  (frm_stb),
    .frm_left (frm_left),
    .blk_mark (blk_mark),
    .ctl      (ctl),
    .pos      (pos),
    .blk_end  (blk_end)
  );

  for (genvar g = 0; g < N_STREAMS; g++) begin : g_strm
    logic          bit_sel_in;
    logic [AW-1:0] ra;
    assign bit_sel_in = (g == STRM_USER) ? u_bit : c_bit;
    assign ra         = (g == STRM_USER) ? ud_raddr : cs_raddr;
    csu_word_bank #(.BLK_FRAMES(BLK_FRAMES), .WORD_W(WORD_W)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .ctl    (ctl),
      .pos    (pos),
      .bit_in (bit_sel_in),
      .raddr  (ra),
      .rdata  (rd_w[g]),
      .chg    (chg_w[g])
    );
  end

  assign cs_rdata = rd_w[STRM_STATUS];
  assign ud_rdata = rd_w[STRM_USER];
  assign cs_chg   = chg_w[STRM_STATUS];
  assign ud_chg   = chg_w[STRM_USER];
endmodule

// File: rtl/csu_capture_chk.sv
module csu_capture_chk #(
  parameter int BLK_FRAMES = 192,
  parameter int WORD_W = 16,
  localparam int N_WORDS = BLK_FRAMES / WORD_W,
  localparam int AW = $clog2(N_WORDS)
) (
  input logic              clk,
  input logic              rst,
  input logic              frm_stb,
  input logic              frm_left,
  input logic              blk_mark,
  input logic [AW-1:0]     cs_raddr,
  input logic [WORD_W-1:0] cs_rdata,
  input logic [AW-1:0]     ud_raddr,
  input logic [WORD_W-1:0] ud_rdata,
  input logic              blk_end,
  input logic              cs_chg,
  input logic              ud_chg
);
  localparam logic [AW:0] NW = (AW + 1)'(N_WORDS);

  // R7
  cs_chg_with_end_chk: assert property (@(posedge clk) disable iff (rst)
    cs_chg |-> blk_end);

  // R8
  ud_chg_with_end_chk: assert property (@(posedge clk) disable iff (rst)
    ud_chg |-> blk_end);

  // R5
  end_follows_frame_chk: assert property (@(posedge clk) disable iff (rst)
    blk_end |-> $past(frm_stb && frm_left));

  // R5
  end_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    blk_end |=> !blk_end);

  // R10
  mark_no_end_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_stb && frm_left && blk_mark) |=> !blk_end);

  // R2
  right_no_end_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_stb && !frm_left) |=> !blk_end);

  // R11
  cs_oob_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, cs_raddr} >= NW) |=> (cs_rdata == '0));

  // R11
  ud_oob_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, ud_raddr} >= NW) |=> (ud_rdata == '0));
endmodule

bind chstat_ubit_capture csu_capture_chk #(
  .BLK_FRAMES(BLK_FRAMES),
  .WORD_W(WORD_W)
) u_chk (.*);

// File: tb/sim_chstat_ubit_capture.sv
`timescale 1ns/1ps
module sim_chstat_ubit_capture;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_stb = 1'b0, frm_left = 1'b0, blk_mark = 1'b0, c_bit = 1'b0, u_bit = 1'b0;
  logic [3:0] cs_raddr = '0, ud_raddr = '0;
  logic [15:0] cs_rdata, ud_rdata;
  logic blk_end, cs_chg, ud_chg;

  int n_cmp = 0;
  int n_bad = 0;
  bit [191:0] prev_cs, prev_ud;
  bit have_prev = 0;

  always #2.5 clk = ~clk;

  chstat_ubit_capture u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input bit left, input bit mark, input bit c, input bit u);
    @(negedge clk);
    frm_stb = 1'b1; frm_left = left; blk_mark = mark; c_bit = c; u_bit = u;
    @(negedge clk);
    frm_stb = 1'b0; blk_mark = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] c, output logic [15:0] u);
    @(negedge clk);
    cs_raddr = 4'(a); ud_raddr = 4'(a);
    @(negedge clk);
    c = cs_rdata; u = ud_rdata;
  endtask

  function automatic bit [191:0] rnd192();
    bit [191:0] v;
    for (int i = 0; i < 6; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  // compare both arrays with expected content (R3, R4, R9) and out-of-range (R11)
  task automatic verify(input bit [191:0] cs, input bit [191:0] ud, input bit valid, input string tag);
    logic [15:0] c, u;
    for (int i = 0; i < 12; i++) begin
      rd(i, c, u);
      chk({"R3 status word ", tag}, c, valid ? cs[16*i +: 16] : 16'h0);
      chk({"R4 user word ", tag}, u, valid ? ud[16*i +: 16] : 16'h0);
    end
    for (int i = 12; i < 16; i++) begin
      rd(i, c, u);
      chk("R11 out-of-range status read", c, 0);
      chk("R11 out-of-range user read", u, 0);
    end
  endtask

  task automatic send_block(input bit [191:0] cs, input bit [191:0] ud, input bit with_right);
    bit mid_bad = 0;
    for (int k = 0; k < 192; k++) begin
      frame(1'b1, k == 0, cs[k], ud[k]);
      if (k < 191) begin
        if (blk_end) mid_bad = 1;
      end else begin
        chk("R5 block end after 192nd frame", blk_end, 1);
        chk("R7 status change flag", cs_chg, (!have_prev || cs != prev_cs));
        chk("R8 user change flag", ud_chg, (!have_prev || ud != prev_ud));
        prev_cs = cs; prev_ud = ud; have_prev = 1;
      end
      if (with_right) begin
        frame(1'b0, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
        if (blk_end) mid_bad = 1;
      end
    end
    chk("R5 R2 no stray block end", mid_bad, 0);
  endtask

  initial begin
    #(100000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit [191:0] a_cs, a_ud, b_cs, b_ud, x_cs, x_ud;
    logic [15:0] c, u;
    bit bad;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 blk_end after reset", blk_end, 0);
    chk("R1 cs_chg after reset", cs_chg, 0);
    chk("R1 ud_chg after reset", ud_chg, 0);
    rd(0, c, u);
    chk("R1 status read before first block", c, 0);
    chk("R1 user read before first block", u, 0);

    // R6 frames before any marker are ignored
    bad = 0;
    for (int k = 0; k < 250; k++) begin
      frame(1'b1, 1'b0, 1'b1, 1'b1);
      if (blk_end) bad = 1;
    end
    chk("R6 no block without marker", bad, 0);
    rd(3, c, u);
    chk("R6 arrays untouched without marker", {c, u}, 0);

    // directed byte layout, first block flags both changes
    a_cs = '0; a_ud = '0;
    a_cs[7:0] = 8'hA5; a_cs[15:8] = 8'h3C; a_cs[183:176] = 8'h81;
    a_ud[191:184] = 8'h96; a_ud[0] = 1'b1;
    send_block(a_cs, a_ud, 1'b0);
    rd(0, c, u);
    chk("R3 byte 0 low, byte 1 high", c, 16'h3CA5);
    chk("R4 user word 0", u, 16'h0001);
    rd(11, c, u);
    chk("R3 byte 22 in word 11 low", c, 16'h0081);
    chk("R4 byte 23 in word 11 high", u, 16'h9600);

    // random block, then repeat with right subframes interleaved (no change)
    a_cs = rnd192(); a_ud = rnd192();
    send_block(a_cs, a_ud, 1'b0);
    verify(a_cs, a_ud, 1'b1, "random A");
    send_block(a_cs, a_ud, 1'b1);
    verify(a_cs, a_ud, 1'b1, "repeat A");

    // single status bit flip at last position
    b_cs = a_cs; b_cs[191] = ~b_cs[191];
    send_block(b_cs, a_ud, 1'b0);
    // single user bit flip at position 0
    b_ud = a_ud; b_ud[0] = ~b_ud[0];
    send_block(b_cs, b_ud, 1'b0);
    verify(b_cs, b_ud, 1'b1, "flips");

    // R10, R9: partial block with different data, then restart with same data
    x_cs = ~b_cs; x_ud = ~b_ud;
    bad = 0;
    for (int k = 0; k < 120; k++) begin
      frame(1'b1, k == 0, x_cs[k], x_ud[k]);
      if (blk_end || cs_chg || ud_chg) bad = 1;
    end
    chk("R10 partial block raises nothing", bad, 0);
    verify(b_cs, b_ud, 1'b1, "R9 during partial");
    send_block(b_cs, b_ud, 1'b0);
    verify(b_cs, b_ud, 1'b1, "R10 after restart");

    // R6 frames after a completed block without marker are ignored
    bad = 0;
    for (int k = 0; k < 200; k++) begin
      frame(1'b1, 1'b0, ~b_cs[k % 192], 1'b1);
      if (blk_end) bad = 1;
    end
    chk("R6 no block after completion without marker", bad, 0);
    verify(b_cs, b_ud, 1'b1, "R6 after idle frames");

    // random mix of changes
    for (int t = 0; t < 6; t++) begin
      a_cs = ($urandom % 2) ? rnd192() : prev_cs;
      a_ud = ($urandom % 2) ? rnd192() : prev_ud;
      send_block(a_cs, a_ud, 1'($urandom % 2));
      verify(a_cs, a_ud, 1'b1, "random mix");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule